// File: doc/BRIEF.md
# Chained Descriptor Walker for One DMA Channel

This block drives one DMA channel from a chain of transfer descriptors kept in memory. Software places the address of the first node in the channel's link register and then writes the control word with the list-enable bit set. The walker reads the node one 32-bit word at a time over a request/valid read port. Once all eight words have arrived, it copies them together into the channel's working registers. It then hands the source address, destination address and length to a separate data mover through a one-cycle start pulse, and waits for that mover's done pulse.

After each completion the walker follows the node's link word. A zero link ends the run and clears the enable bits. A link that leads back to an earlier node makes the chain circular, and the walker keeps going until software cancels it.

The walker raises an event pulse when the first node of a run is loaded, and again on every completion. Software can read the working registers through an eight-word window at any time. It can write them only while the walker is idle.

Top module: `dma_chain_walker`

## Requirements
- R1: After reset the walker is idle: no memory request, no start pulse, no event, and all eight working registers read as zero.
- R2: Node words are, in memory order: general config, read-port config, source address, destination address, size, link, done count, control. They land in window words 0 through 7 in that same order. Word 4 reads back with only its low 24 bits.
- R3: In the cycle after the eighth word is accepted, `xfer_start` pulses for exactly one cycle. At the same time `xfer_src` shows word 2, `xfer_dst` shows word 3, and `xfer_len` shows the low 24 bits of word 4, which hold the byte count minus one.
- R4: A node is fetched as eight reads at the node address plus 0, 4, 8 and so on up to 28. Each request stays high with a stable address until `mem_rvalid` returns its word.
- R5: `evt` pulses for one cycle together with the first start pulse of a run. It pulses again on each completion the walker accepts. A completion that arrives in the same cycle as a cancel produces no event.
- R6: After a completion, a nonzero link word starts the fetch of the node at that address. A zero link returns the walker to idle and clears control bits 4 and 0.
- R7: A chain whose last link points back to its head is walked over and over, with no limit, until a cancel arrives.
- R8: Writing control word 7 with bit 20 set cancels the walker. Cancel wins over a completion or a final word arriving in the same cycle. An outstanding read is still waited for and then discarded. A partly fetched node never reaches the working registers. The walker ends idle with control bits 4 and 0 cleared.
- R9: While the walker is busy, writes to any window word are ignored, except a control write that carries the cancel bit.
- R10: While the walker is idle, writing the control word with bit 4 set and bit 20 clear starts fetching at the address held in window word 5. A control write with bit 4 clear does not start a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Window write strobe |
| sw_word | input | 3 | Window word index (byte offset bits 4:2) |
| sw_wdata | input | 32 | Window write data |
| sw_rdata | output | 32 | Window read data for `sw_word` |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_rvalid | input | 1 | Read word returned, request accepted |
| mem_rdata | input | 32 | Returned descriptor word |
| xfer_start | output | 1 | One-cycle transfer start |
| xfer_src | output | 32 | Transfer source address |
| xfer_dst | output | 32 | Transfer destination address |
| xfer_len | output | 24 | Byte count minus one |
| xfer_done | input | 1 | Transfer finished pulse from the data mover |
| evt | output | 1 | Load/completion event pulse |
| busy | output | 1 | Walker not idle |

## Verification
A software cancel and a completion from the data mover can land in the same cycle. So can a cancel and the return of a node's last word. In both cases the cancel must win. The bench holds back the model mover's automatic done, then drives the done pulse and the cancel write on the same clock edge. It expects no further event, no new start pulse, and an idle walker with control bits 4 and 0 cleared. A separate run cancels while a slow memory is still returning a node, and expects the previously loaded working registers to be left untouched.

// File: rtl/dma_chain_walker.sv
module dma_chain_walker #(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [4:2]       sw_word,
  input  logic [31:0]      sw_wdata,
  output logic [31:0]      sw_rdata,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             xfer_start,
  output logic [31:0]      xfer_src,
  output logic [31:0]      xfer_dst,
  output logic [LEN_W-1:0] xfer_len,
  input  logic             xfer_done,
  output logic             evt,
  output logic             busy
);
  localparam int NW = 8;
  localparam logic [2:0] IX_SRC = 3'd2, IX_DST = 3'd3, IX_SZ = 3'd4,
                         IX_LNK = 3'd5, IX_CTL = 3'd7;
  localparam int B_CAN = 20, B_LST = 4, B_EN = 0;
  localparam logic [31:0] SZ_MASK = (32'h1 << LEN_W) - 32'h1;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DRAIN, S_BUSY} st_t;

  st_t         st;
  logic [31:0] wk [NW];
  logic [31:0] sh [NW];
  logic [2:0]  widx;
  logic [31:0] fbase;
  logic        first;

  wire ctl_wr = sw_we && sw_word == IX_CTL;
  wire cancel = ctl_wr && sw_wdata[B_CAN];
  wire go     = ctl_wr && !sw_wdata[B_CAN] && sw_wdata[B_LST] && st == S_IDLE;

  assign busy     = st != S_IDLE;
  assign mem_req  = st == S_FETCH || st == S_DRAIN;
  assign mem_addr = fbase + {27'd0, widx, 2'b00};
  assign xfer_src = wk[IX_SRC];
  assign xfer_dst = wk[IX_DST];
  assign xfer_len = wk[IX_SZ][LEN_W-1:0];
  assign sw_rdata = (sw_word == IX_SZ) ? (wk[IX_SZ] & SZ_MASK) : wk[sw_word];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      widx       <= '0;
      fbase      <= '0;
      first      <= 1'b0;
      xfer_start <= 1'b0;
      evt        <= 1'b0;
      for (int i = 0; i < NW; i++) begin
        wk[i] <= '0;
        sh[i] <= '0;
      end
    end else begin
      xfer_start <= 1'b0;
      evt        <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cancel) begin
            wk[IX_CTL][B_LST] <= 1'b0;
            wk[IX_CTL][B_EN]  <= 1'b0;
          end else if (sw_we) begin
            if (sw_word == IX_CTL) wk[IX_CTL] <= sw_wdata & ~(32'h1 << B_CAN);
            else                   wk[sw_word] <= sw_wdata;
          end
          if (go) begin
            st    <= S_FETCH;
            fbase <= wk[IX_LNK];
            widx  <= '0;
            first <= 1'b1;
          end
        end
        S_FETCH: begin
          if (cancel) begin
            st                <= mem_rvalid ? S_IDLE : S_DRAIN;
            wk[IX_CTL][B_LST] <= 1'b0;
            wk[IX_CTL][B_EN]  <= 1'b0;
          end else if (mem_rvalid) begin
            if (widx == 3'(NW - 1)) begin
              for (int i = 0; i < NW - 1; i++) wk[i] <= sh[i];
              wk[NW-1]   <= mem_rdata;
              xfer_start <= 1'b1;
              evt        <= first;
              first      <= 1'b0;
              st         <= S_BUSY;
            end else begin
              sh[widx] <= mem_rdata;
              widx     <= widx + 3'd1;
            end
          end
        end
        S_DRAIN: begin
          if (mem_rvalid) st <= S_IDLE;
        end
        S_BUSY: begin
          if (cancel) begin
            st                <= S_IDLE;
            wk[IX_CTL][B_LST] <= 1'b0;
            wk[IX_CTL][B_EN]  <= 1'b0;
          end else if (xfer_done) begin
            evt <= 1'b1;
            if (wk[IX_LNK] == '0) begin
              st                <= S_IDLE;
              wk[IX_CTL][B_LST] <= 1'b0;
              wk[IX_CTL][B_EN]  <= 1'b0;
            end else begin
              st    <= S_FETCH;
              fbase <= wk[IX_LNK];
              widx  <= '0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> busy); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && mem_rvalid && !cancel && widx != 3'(NW - 1))
      |=> (mem_addr == $past(mem_addr) + 32'd4)); // R4
  AST_LINK_END: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY && xfer_done && !cancel && wk[IX_LNK] == '0)
      |=> (!busy && !sw_rdata[B_EN] || sw_word != IX_CTL || !busy)); // R6
  AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && (st == S_IDLE || st == S_BUSY || (st == S_FETCH && mem_rvalid)))
      |=> (!busy && !xfer_start && !evt)); // R8
  AST_CANCEL_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && st == S_FETCH && !mem_rvalid) |=> (mem_req && !xfer_start)); // R8
endmodule

// File: tb/sim_dma_chain_walker.sv
`timescale 1ns/1ps
module sim_dma_chain_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        sw_we = 1'b0;
  logic [4:2]  sw_word = '0;
  logic [31:0] sw_wdata = '0;
  wire  [31:0] sw_rdata;
  wire         mem_req;
  wire  [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  wire         xfer_start;
  wire  [31:0] xfer_src, xfer_dst;
  wire  [23:0] xfer_len;
  logic        eng_done = 1'b0, man_done = 1'b0;
  wire         xfer_done = eng_done | man_done;
  wire         evt, busy;

  dma_chain_walker u0 (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_word(sw_word), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .xfer_start(xfer_start), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
    .xfer_len(xfer_len), .xfer_done(xfer_done), .evt(evt), .busy(busy));

  logic [31:0] mem [256];
  logic [31:0] flog [64];
  int errors = 0, checks = 0;
  int n_start = 0, n_evt = 0, n_evt_st = 0, fcnt = 0, mem_gap = 0, eng_lat = 2;
  bit auto_eng = 1'b1, done = 1'b0;
  logic [31:0] l_src = '0, l_dst = '0;
  logic [23:0] l_len = '0;

  // src, dst, raw size word
  localparam logic [31:0] VEC [4][3] = '{
    '{32'h1000_0000, 32'h2000_0000, 32'h0000_003F},
    '{32'h0000_0A04, 32'h8000_0000, 32'h00FF_FFFF},
    '{32'h1234_5670, 32'h0BAD_F00C, 32'hFF00_0010},
    '{32'h0000_0000, 32'hFFFF_FFFC, 32'h0000_0000}};

  initial begin
    int gcnt;
    gcnt = 0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (gcnt >= mem_gap) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem[mem_addr[9:2]];
          flog[fcnt % 64] = mem_addr;
          fcnt++;
          gcnt = 0;
        end else begin
          mem_rvalid = 1'b0;
          gcnt++;
        end
      end else begin
        mem_rvalid = 1'b0;
        gcnt = 0;
      end
    end
  end

  initial begin
    int tmr;
    bit pend;
    tmr = 0; pend = 1'b0;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (pend) begin
        if (tmr == 0) begin eng_done = 1'b1; pend = 1'b0; end
        else tmr--;
      end
      if (xfer_start) begin
        n_start++;
        l_src = xfer_src; l_dst = xfer_dst; l_len = xfer_len;
        pend = auto_eng; tmr = eng_lat;
      end
      if (evt) begin
        n_evt++;
        if (xfer_start) n_evt_st++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [4:0] off, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_word = off[4:2]; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic sw_read(input logic [4:0] off, output logic [31:0] d);
    @(negedge clk);
    sw_word = off[4:2];
    #1 d = sw_rdata;
  endtask

  task automatic wait_idle(input string req);
    int k;
    k = 0;
    @(negedge clk);
    while (busy && k < 3000) begin @(negedge clk); k++; end
    if (busy) chk(1'b0, req, 32'd1, 32'd0);
  endtask

  task automatic put_node(input logic [31:0] base, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] sz, input logic [31:0] lnk);
    int ix;
    ix = int'(base[9:2]);
    mem[ix]   = 32'hC0DE_0000 | base;
    mem[ix+1] = 32'h0000_1230;
    mem[ix+2] = s;
    mem[ix+3] = d;
    mem[ix+4] = sz;
    mem[ix+5] = lnk;
    mem[ix+6] = 32'h0;
    mem[ix+7] = 32'h0000_0011;
  endtask

  task automatic launch(input logic [31:0] base);
    sw_write(5'h14, base);
    sw_write(5'h1C, 32'h0000_0011);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int s0, e0, es0, k;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!mem_req && !xfer_start && !evt && !busy, "R1", {28'd0, mem_req, xfer_start, evt, busy}, 32'd0);
    for (int w = 0; w < 8; w++) begin
      sw_read(5'(w * 4), rd);
      chk(rd == 32'd0, "R1", rd, 32'd0);
    end

    // table walk: single-node runs
    for (int v = 0; v < 4; v++) begin
      s0 = n_start; e0 = n_evt; es0 = n_evt_st; fcnt = 0;
      put_node(32'h100, VEC[v][0], VEC[v][1], VEC[v][2], 32'h0);
      launch(32'h100);
      wait_idle("R6");
      chk(n_start == s0 + 1 && l_src == VEC[v][0], "R3", l_src, VEC[v][0]);
      chk(l_dst == VEC[v][1], "R3", l_dst, VEC[v][1]);
      chk(l_len == VEC[v][2][23:0], "R3", {8'd0, l_len}, {8'd0, VEC[v][2][23:0]});
      chk(n_evt == e0 + 2 && n_evt_st == es0 + 1, "R5", n_evt - e0, 32'd2);
      sw_read(5'h1C, rd);
      chk((rd & 32'h11) == 32'h0, "R6", rd, 32'h0);
      sw_read(5'h08, rd);
      chk(rd == VEC[v][0], "R2", rd, VEC[v][0]);
      sw_read(5'h10, rd);
      chk(rd == (VEC[v][2] & 32'h00FF_FFFF), "R2", rd, VEC[v][2] & 32'h00FF_FFFF);
      if (v == 0) begin
        sw_read(5'h00, rd);
        chk(rd == 32'hC0DE_0100, "R2", rd, 32'hC0DE_0100);
        chk(fcnt == 8, "R4", fcnt, 32'd8);
        for (int w = 0; w < 8; w++)
          chk(flog[w] == 32'h100 + 32'(w * 4), "R4", flog[w], 32'h100 + 32'(w * 4));
      end
    end

    // two-node chain following the link
    put_node(32'h200, 32'hAAAA_0000, 32'hBBBB_0000, 32'h7, 32'h240);
    put_node(32'h240, 32'hCCCC_0000, 32'hDDDD_0000, 32'h9, 32'h0);
    s0 = n_start; fcnt = 0;
    launch(32'h200);
    wait_idle("R6");
    chk(n_start == s0 + 2, "R6", n_start - s0, 32'd2);
    chk(l_src == 32'hCCCC_0000, "R6", l_src, 32'hCCCC_0000);
    chk(flog[8] == 32'h240, "R6", flog[8], 32'h240);

    // control write without list-enable does not start
    sw_write(5'h1C, 32'h0000_0001);
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req, "R10", {31'd0, busy}, 32'd0);

    // circular chain, then cancel
    put_node(32'h300, 32'h3000_0000, 32'h3100_0000, 32'h3, 32'h340);
    put_node(32'h340, 32'h3400_0000, 32'h3500_0000, 32'h3, 32'h300);
    s0 = n_start;
    launch(32'h300);
    k = 0;
    while (n_start < s0 + 5 && k < 2000) begin @(negedge clk); k++; end
    chk(n_start >= s0 + 5, "R7", n_start - s0, 32'd5);
    chk(l_src == 32'h3000_0000, "R7", l_src, 32'h3000_0000);
    sw_write(5'h1C, 32'h0010_0000);
    repeat (2) @(negedge clk);
    s0 = n_start;
    chk(!busy && !mem_req, "R8", {31'd0, busy}, 32'd0);
    repeat (20) @(negedge clk);
    chk(n_start == s0, "R7", n_start, s0);
    sw_read(5'h1C, rd);
    chk((rd & 32'h11) == 32'h0, "R8", rd, 32'h0);

    // cancel during a slow fetch leaves working registers untouched
    put_node(32'h400, 32'hDEAD_0000, 32'hBEEF_0000, 32'h5, 32'h0);
    sw_write(5'h08, 32'h1234_5678);
    mem_gap = 3;
    s0 = n_start;
    launch(32'h400);
    repeat (9) @(negedge clk);
    sw_write(5'h1C, 32'h0010_0000);
    wait_idle("R8");
    mem_gap = 0;
    sw_read(5'h08, rd);
    chk(rd == 32'h1234_5678, "R8", rd, 32'h1234_5678);
    chk(n_start == s0, "R8", n_start, s0);
    sw_read(5'h14, rd);
    chk(rd == 32'h400, "R8", rd, 32'h400);

    // busy writes ignored
    eng_lat = 30;
    put_node(32'h100, 32'hABCD_0000, 32'h1, 32'h2, 32'h0);
    s0 = n_start;
    launch(32'h100);
    k = 0;
    while (n_start == s0 && k < 500) begin @(negedge clk); k++; end
    sw_write(5'h08, 32'h5555_5555);
    sw_read(5'h08, rd);
    chk(rd == 32'hABCD_0000, "R9", rd, 32'hABCD_0000);
    wait_idle("R9");
    eng_lat = 2;

    // cancel and completion in the same cycle
    auto_eng = 1'b0;
    s0 = n_start;
    launch(32'h100);
    k = 0;
    while (n_start == s0 && k < 500) begin @(negedge clk); k++; end
    repeat (2) @(negedge clk);
    e0 = n_evt;
    sw_we = 1'b1; sw_word = 3'd7; sw_wdata = 32'h0010_0000; man_done = 1'b1;
    @(negedge clk);
    sw_we = 1'b0; man_done = 1'b0;
    repeat (3) @(negedge clk);
    chk(n_evt == e0, "R5", n_evt - e0, 32'd0);
    chk(!busy && n_start == s0 + 1, "R8", {31'd0, busy}, 32'd0);
    auto_eng = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule